// File: doc/BRIEF.md
# Secure Debug Enable Control Register

This block holds a 32-bit control register with two live bits. The bits grant debug permission to the least privileged level while it runs in the secure state. The block sits behind a system-register access port. On every cycle where a request is presented, it matches the request's coprocessor encoding against the register's own encoding. For a request that hits, it then works out whether the access completes, is undefined, or is trapped to a higher privilege level. That decision depends on:
- the current privilege level;
- the security state;
- the implementation feature flags;
- the register-width mode of levels 1, 2 and 3;
- a set of trap-control bits supplied by neighbouring configuration registers.

The outcome is produced in the same cycle as the request, together with a target level and a syndrome value. The requester can therefore raise the matching exception or retire the instruction. A write that completes updates the two bits on the next clock edge. The two stored bits are turned into permission signals for secure level 0. These signals are forced off whenever secure level 1 runs in 64-bit mode, or when the register is not implemented.

Top module: `secdbg_enable_reg`

## Requirements
- R1: Bit 0 holds the invasive-debug enable and bit 1 holds the non-invasive-debug enable. Bits 31..2 always read as zero, and writes to them are discarded.
- R2: A request hits only when valid is high and coproc=4'hF, opc1=3'h0, crn=4'h1, crm=4'h1 and opc2=3'h1. A miss gives outcome 0 (none), rdata zero and no register change.
- R3: The register is present when (has_l3 and l3_aa32_ok) or (l1_aa32_ok and has_sec_l1) holds. When it is absent, every hit gives outcome 2 (undefined).
- R4: Every hit from level 0 or level 2 gives outcome 2 (undefined).
- R5: At level 1 the checks run in a fixed order and the first match wins:
  - l2_en, l2_is64 and l2_cp_trap all set give 3 (trap to level 2);
  - l2_en with l2_is64 clear and l2_cp_trap set gives 4 (hypervisor trap);
  - a non-secure state gives 2;
  - l2_en and l2_is64 with l2_tde or l2_tda set give 3;
  - has_l3, l3_is64 and l3_tda all set give 5 (trap to level 3);
  - otherwise the result is 1 (complete).
- R6: Outcomes 3 and 4 report trap_lvl 2, and outcome 5 reports trap_lvl 3. All three report syndrome 6'h03. Every other outcome reports trap_lvl 0 and syndrome 0.
- R7: At level 3, a read that hits completes (outcome 1). A write that hits is undefined while sec_wr_block is high, and completes otherwise.
- R8: inv_en equals stored bit 0 and ninv_en equals stored bit 1, but only while the register is present and sec_l1_is64 is low. Otherwise both are 0.
- R9: The active-low reset clears both stored bits.
- R10: A completed write loads wdata[1:0] on the next rising clock edge. A completed read returns the stored bits on rdata[1:0] in the same cycle.
- R11: A read that does not complete returns zero. A write that does not complete leaves the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 = write, 0 = read |
| enc_coproc | input | 4 | Coprocessor number field |
| enc_opc1 | input | 3 | First opcode field |
| enc_crn | input | 4 | Primary register field |
| enc_crm | input | 4 | Secondary register field |
| enc_opc2 | input | 3 | Second opcode field |
| wdata | input | 32 | Write data |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | Current security state is secure |
| has_l3 | input | 1 | Level 3 implemented |
| l3_aa32_ok | input | 1 | Level 3 supports 32-bit mode |
| l1_aa32_ok | input | 1 | Level 1 supports 32-bit mode |
| has_sec_l1 | input | 1 | Secure level 1 implemented |
| l2_en | input | 1 | Level 2 enabled in current state |
| l2_is64 | input | 1 | Level 2 runs in 64-bit mode |
| l3_is64 | input | 1 | Level 3 runs in 64-bit mode |
| sec_l1_is64 | input | 1 | Secure level 1 runs in 64-bit mode |
| l2_cp_trap | input | 1 | Level 2 coprocessor-register trap bit |
| l2_tde | input | 1 | Level 2 debug-exception routing bit |
| l2_tda | input | 1 | Level 2 debug-access trap bit |
| l3_tda | input | 1 | Level 3 debug-access trap bit |
| sec_wr_block | input | 1 | External disable of level 3 writes |
| rdata | output | 32 | Read data |
| outcome | output | 3 | 0 none, 1 complete, 2 undefined, 3 trap L2, 4 hyp trap, 5 trap L3 |
| trap_lvl | output | 2 | Target level of a trap |
| syndrome | output | 6 | Syndrome class of a trap |
| inv_en | output | 1 | Invasive debug allowed at secure level 0 |
| ninv_en | output | 1 | Non-invasive debug allowed at secure level 0 |

## Verification
The level 1 chain is driven with trap bits that overlap, so that each test separates adjacent priorities:
- a coprocessor trap in a non-secure state must still trap, not be undefined;
- the 32-bit second level must pick the hypervisor trap over the 64-bit trap;
- a second-level debug trap must win over a third-level one;
- a third-level debug trap must be ignored while level 3 is 32-bit.

The level 3 write gate is tried with the block input both high and low, and the two failed writes are followed by read-backs that show the stored bits kept their value. Near-miss encodings differ from the real one in a single field. The enable outputs are swept across the width mode of secure level 1 and the presence conditions.

// File: rtl/secdbg_pkg.sv
package secdbg_pkg;
  typedef enum logic [2:0] {
    OC_NONE    = 3'd0,
    OC_DONE    = 3'd1,
    OC_UNDEF   = 3'd2,
    OC_TRAP_L2 = 3'd3,
    OC_HYP     = 3'd4,
    OC_TRAP_L3 = 3'd5
  } outcome_e;

  localparam logic [3:0] ENC_COPROC = 4'hF;
  localparam logic [2:0] ENC_OPC1   = 3'h0;
  localparam logic [3:0] ENC_CRN    = 4'h1;
  localparam logic [3:0] ENC_CRM    = 4'h1;
  localparam logic [2:0] ENC_OPC2   = 3'h1;

  localparam int INV_BIT  = 0;
  localparam int NINV_BIT = 1;
  localparam int LIVE_W   = 2;

  localparam logic [1:0] LVL0 = 2'd0;
  localparam logic [1:0] LVL1 = 2'd1;
  localparam logic [1:0] LVL2 = 2'd2;
  localparam logic [1:0] LVL3 = 2'd3;
endpackage

// File: rtl/secdbg_enc_match.sv
module secdbg_enc_match
  import secdbg_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit
);
  function automatic logic enc_equal(logic [3:0] cp, logic [2:0] o1,
                                     logic [3:0] n, logic [3:0] m, logic [2:0] o2);
    return (cp == ENC_COPROC) && (o1 == ENC_OPC1) && (n == ENC_CRN) &&
           (m == ENC_CRM) && (o2 == ENC_OPC2);
  endfunction

  assign hit = valid && enc_equal(coproc, opc1, crn, crm, opc2);
endmodule

// File: rtl/secdbg_access_chk.sv
module secdbg_access_chk
  import secdbg_pkg::*;
#(
  parameter int SYND_W = 6,
  parameter logic [SYND_W-1:0] TRAP_SYND = 6'h03
) (
  input  logic              hit,
  input  logic              is_write,
  input  logic [1:0]        lvl,
  input  logic              secure,
  input  logic              present,
  input  logic              has_l3,
  input  logic              l2_en,
  input  logic              l2_is64,
  input  logic              l3_is64,
  input  logic              l2_cp_trap,
  input  logic              l2_tde,
  input  logic              l2_tda,
  input  logic              l3_tda,
  input  logic              wr_block,
  output outcome_e          result,
  output logic [1:0]        trap_lvl,
  output logic [SYND_W-1:0] syndrome
);
  // Level 1 priority chain, first match wins.
  function automatic outcome_e lvl1_chain(logic sec, logic e2, logic w64_2,
                                          logic cpt, logic tde, logic tda2,
                                          logic h3, logic w64_3, logic tda3);
    if (e2 && w64_2 && cpt)              return OC_TRAP_L2;
    else if (e2 && !w64_2 && cpt)        return OC_HYP;
    else if (!sec)                       return OC_UNDEF;
    else if (e2 && w64_2 && (tde || tda2)) return OC_TRAP_L2;
    else if (h3 && w64_3 && tda3)        return OC_TRAP_L3;
    else                                 return OC_DONE;
  endfunction

  function automatic logic [1:0] target_of(outcome_e oc);
    case (oc)
      OC_TRAP_L2, OC_HYP: return LVL2;
      OC_TRAP_L3:         return LVL3;
      default:            return LVL0;
    endcase
  endfunction

  always_comb begin
    result = OC_NONE;
    if (hit) begin
      if (!present) begin
        result = OC_UNDEF;
      end else begin
        case (lvl)
          LVL1: result = lvl1_chain(secure, l2_en, l2_is64, l2_cp_trap, l2_tde,
                                    l2_tda, has_l3, l3_is64, l3_tda);
          LVL3: result = (is_write && wr_block) ? OC_UNDEF : OC_DONE;
          default: result = OC_UNDEF;
        endcase
      end
    end
  end

  assign trap_lvl = target_of(result);
  assign syndrome = (trap_lvl != LVL0) ? TRAP_SYND : '0;
endmodule

// File: rtl/secdbg_bits_store.sv
module secdbg_bits_store
  import secdbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [LIVE_W-1:0] wbits,
  output logic [LIVE_W-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits <= '0;
    else if (commit) bits <= wbits;
  end
endmodule

// File: rtl/secdbg_perm.sv
module secdbg_perm
  import secdbg_pkg::*;
(
  input  logic [LIVE_W-1:0] bits,
  input  logic              present,
  input  logic              sec_l1_is64,
  output logic              inv_en,
  output logic              ninv_en
);
  logic gate_open;
  assign gate_open = present && !sec_l1_is64;
  assign inv_en    = gate_open && bits[INV_BIT];
  assign ninv_en   = gate_open && bits[NINV_BIT];
endmodule

// File: rtl/secdbg_enable_reg.sv
module secdbg_enable_reg
  import secdbg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYND_W = 6,
  parameter logic [SYND_W-1:0] TRAP_SYND = 6'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [3:0]        enc_coproc,
  input  logic [2:0]        enc_opc1,
  input  logic [3:0]        enc_crn,
  input  logic [3:0]        enc_crm,
  input  logic [2:0]        enc_opc2,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        cur_lvl,
  input  logic              secure,
  input  logic              has_l3,
  input  logic              l3_aa32_ok,
  input  logic              l1_aa32_ok,
  input  logic              has_sec_l1,
  input  logic              l2_en,
  input  logic              l2_is64,
  input  logic              l3_is64,
  input  logic              sec_l1_is64,
  input  logic              l2_cp_trap,
  input  logic              l2_tde,
  input  logic              l2_tda,
  input  logic              l3_tda,
  input  logic              sec_wr_block,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        outcome,
  output logic [1:0]        trap_lvl,
  output logic [SYND_W-1:0] syndrome,
  output logic              inv_en,
  output logic              ninv_en
);
  logic              enc_hit;
  logic              reg_present;
  outcome_e          chk_result;
  logic              wr_commit;
  logic              rd_complete;
  logic [LIVE_W-1:0] stored_bits;
  logic              unused_wdata_hi;

  assign reg_present = (has_l3 && l3_aa32_ok) || (l1_aa32_ok && has_sec_l1);

  secdbg_enc_match u_match (
    .valid (acc_valid), .coproc(enc_coproc), .opc1(enc_opc1),
    .crn   (enc_crn),   .crm   (enc_crm),    .opc2(enc_opc2),
    .hit   (enc_hit)
  );

  secdbg_access_chk #(.SYND_W(SYND_W), .TRAP_SYND(TRAP_SYND)) u_chk (
    .hit       (enc_hit),    .is_write(acc_write), .lvl     (cur_lvl),
    .secure    (secure),     .present (reg_present), .has_l3(has_l3),
    .l2_en     (l2_en),      .l2_is64 (l2_is64),   .l3_is64 (l3_is64),
    .l2_cp_trap(l2_cp_trap), .l2_tde  (l2_tde),    .l2_tda  (l2_tda),
    .l3_tda    (l3_tda),     .wr_block(sec_wr_block),
    .result    (chk_result), .trap_lvl(trap_lvl),  .syndrome(syndrome)
  );

  assign wr_commit   = (chk_result == OC_DONE) && acc_write;
  assign rd_complete = (chk_result == OC_DONE) && !acc_write;

  secdbg_bits_store u_store (
    .clk(clk), .rst_n(rst_n), .commit(wr_commit),
    .wbits(wdata[LIVE_W-1:0]), .bits(stored_bits)
  );

  secdbg_perm u_perm (
    .bits(stored_bits), .present(reg_present), .sec_l1_is64(sec_l1_is64),
    .inv_en(inv_en), .ninv_en(ninv_en)
  );

  always_comb begin
    rdata = '0;
    if (rd_complete) rdata[LIVE_W-1:0] = stored_bits;
  end

  assign outcome = chk_result;
  assign unused_wdata_hi = ^wdata[DATA_W-1:LIVE_W];
endmodule

// File: rtl/secdbg_enable_chk.sv
module secdbg_enable_chk
  import secdbg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYND_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic              present,
  input logic              acc_write,
  input logic [1:0]        cur_lvl,
  input logic              wr_block,
  input logic [2:0]        outcome,
  input logic [1:0]        trap_lvl,
  input logic [SYND_W-1:0] syndrome,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        stored,
  input logic [1:0]        wdata_lo,
  input logic              wr_commit
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:LIVE_W] == '0);

  a_r2_miss_none: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (outcome == OC_NONE && rdata == '0));

  a_r3_absent_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !present) |-> outcome == OC_UNDEF);

  a_r4_low_lvl_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (cur_lvl == LVL0 || cur_lvl == LVL2)) |-> outcome == OC_UNDEF);

  a_r6_trap_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == OC_TRAP_L2 || outcome == OC_HYP || outcome == OC_TRAP_L3)
      |-> syndrome == 6'h03);

  a_r6_plain_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == OC_NONE || outcome == OC_DONE || outcome == OC_UNDEF)
      |-> (trap_lvl == 2'd0 && syndrome == '0));

  a_r7_l3_read_done: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && present && cur_lvl == LVL3 && !acc_write) |-> outcome == OC_DONE);

  a_r7_l3_write_block: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && present && cur_lvl == LVL3 && acc_write && wr_block)
      |-> outcome == OC_UNDEF);

  a_r10_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> stored == $past(wdata_lo));

  a_r11_fail_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && acc_write && outcome != OC_DONE) |=> $stable(stored));
endmodule

bind secdbg_enable_reg secdbg_enable_chk #(.DATA_W(DATA_W), .SYND_W(SYND_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .hit(enc_hit), .present(reg_present),
  .acc_write(acc_write), .cur_lvl(cur_lvl), .wr_block(sec_wr_block),
  .outcome(outcome), .trap_lvl(trap_lvl), .syndrome(syndrome),
  .rdata(rdata), .stored(stored_bits), .wdata_lo(wdata[1:0]),
  .wr_commit(wr_commit)
);

// File: tb/sim_secdbg_enable_reg.sv
module sim_secdbg_enable_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0;
  logic [3:0] enc_coproc = 4'hF;
  logic [2:0] enc_opc1 = 3'h0;
  logic [3:0] enc_crn = 4'h1, enc_crm = 4'h1;
  logic [2:0] enc_opc2 = 3'h1;
  logic [31:0] wdata = '0;
  logic [1:0] cur_lvl = 2'd3;
  logic secure = 1, has_l3 = 1, l3_aa32_ok = 1, l1_aa32_ok = 1, has_sec_l1 = 1;
  logic l2_en = 0, l2_is64 = 0, l3_is64 = 0, sec_l1_is64 = 0;
  logic l2_cp_trap = 0, l2_tde = 0, l2_tda = 0, l3_tda = 0, sec_wr_block = 0;
  logic [31:0] rdata;
  logic [2:0] outcome;
  logic [1:0] trap_lvl;
  logic [5:0] syndrome;
  logic inv_en, ninv_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  secdbg_enable_reg u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic defaults();
    acc_valid = 0; acc_write = 0; wdata = '0;
    enc_coproc = 4'hF; enc_opc1 = 3'h0; enc_crn = 4'h1; enc_crm = 4'h1; enc_opc2 = 3'h1;
    cur_lvl = 2'd3; secure = 1; has_l3 = 1; l3_aa32_ok = 1; l1_aa32_ok = 1; has_sec_l1 = 1;
    l2_en = 0; l2_is64 = 0; l3_is64 = 0; sec_l1_is64 = 0;
    l2_cp_trap = 0; l2_tde = 0; l2_tda = 0; l3_tda = 0; sec_wr_block = 0;
  endtask

  // Present an access at the falling edge; outputs settle before the rising edge.
  task automatic access(logic wr, logic [1:0] lvl, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; cur_lvl = lvl; wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    #1;
  endtask

  // Read back stored bits through a level 3 read.
  task automatic read_back(output logic [31:0] v);
    logic [1:0] sv_lvl;
    sv_lvl = cur_lvl;
    access(0, 2'd3, '0);
    v = rdata;
    cur_lvl = sv_lvl;
    idle();
  endtask

  task automatic write_l3(logic [31:0] d);
    access(1, 2'd3, d);
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9 inv_en after reset", {31'd0, inv_en}, 0);
    check("R9 ninv_en after reset", {31'd0, ninv_en}, 0);
    read_back(v);
    check("R9 bits after reset", v, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    access(1, 2'd3, 32'hFFFF_FFFE);
    check("R10 write outcome", {29'd0, outcome}, 1);
    idle();
    read_back(v);
    check("R1 upper bits read zero, bit1 set", v, 32'h2);
    write_l3(32'hFFFF_FFFD);
    read_back(v);
    check("R1 bit0 only", v, 32'h1);
    access(0, 2'd3, '0);
    check("R10 same-cycle read", rdata, 32'h1);
    idle();
  endtask

  task automatic t_encoding();
    logic [31:0] v;
    write_l3(32'h0);
    access(1, 2'd3, 32'h3); enc_crm = 4'h2; #1;
    check("R2 crm miss outcome", {29'd0, outcome}, 0);
    idle(); enc_crm = 4'h1;
    access(1, 2'd3, 32'h3); enc_opc2 = 3'h0; #1;
    check("R2 opc2 miss outcome", {29'd0, outcome}, 0);
    idle(); enc_opc2 = 3'h1;
    access(0, 2'd3, 0); enc_coproc = 4'hE; #1;
    check("R2 coproc miss rdata", rdata, 0);
    idle(); enc_coproc = 4'hF;
    read_back(v);
    check("R2 miss leaves bits", v, 0);
  endtask

  task automatic t_absent();
    l3_aa32_ok = 0; has_sec_l1 = 0;
    access(0, 2'd3, 0);
    check("R3 absent undefined", {29'd0, outcome}, 2);
    check("R8 absent enables off", {30'd0, inv_en, ninv_en}, 0);
    idle();
    has_l3 = 0; has_sec_l1 = 1; l3_aa32_ok = 1;
    access(0, 2'd1, 0);
    check("R3 present via level1", {29'd0, outcome}, 1);
    idle();
    defaults();
  endtask

  task automatic t_low_levels();
    logic [31:0] v;
    write_l3(32'h3);
    access(0, 2'd0, 0);
    check("R4 level0 undefined", {29'd0, outcome}, 2);
    check("R11 failed read zero", rdata, 0);
    access(1, 2'd2, 32'h0);
    check("R4 level2 undefined", {29'd0, outcome}, 2);
    idle();
    read_back(v);
    check("R11 failed write keeps bits", v, 32'h3);
  endtask

  task automatic t_lvl1_chain();
    logic [31:0] v;
    l2_en = 1; l2_is64 = 1; l2_cp_trap = 1; secure = 0; l2_tde = 1;
    access(0, 2'd1, 0);
    check("R5 step1 trap L2", {29'd0, outcome}, 3);
    check("R6 trap L2 target", {30'd0, trap_lvl}, 2);
    check("R6 syndrome", {26'd0, syndrome}, 32'h03);
    l2_is64 = 0; #1;
    check("R5 step2 hyp trap", {29'd0, outcome}, 4);
    check("R6 hyp target", {30'd0, trap_lvl}, 2);
    l2_en = 0; #1;
    check("R5 step3 non-secure undef", {29'd0, outcome}, 2);
    check("R6 undef no syndrome", {26'd0, syndrome}, 0);
    secure = 1; l2_cp_trap = 0; l2_en = 1; l2_is64 = 1; l2_tde = 0; l2_tda = 1;
    has_l3 = 1; l3_is64 = 1; l3_tda = 1; #1;
    check("R5 step4 tda trap L2", {29'd0, outcome}, 3);
    l2_tda = 0; l2_tde = 1; #1;
    check("R5 step4 tde trap L2", {29'd0, outcome}, 3);
    l2_is64 = 0; #1;
    check("R5 step5 trap L3", {29'd0, outcome}, 5);
    check("R6 trap L3 target", {30'd0, trap_lvl}, 3);
    check("R6 L3 syndrome", {26'd0, syndrome}, 32'h03);
    l3_is64 = 0; #1;
    check("R5 step6 complete", {29'd0, outcome}, 1);
    idle();
    l3_is64 = 1;
    access(1, 2'd1, 32'h2);
    check("R11 trapped write outcome", {29'd0, outcome}, 5);
    idle();
    defaults();
    read_back(v);
    check("R11 trapped write keeps bits", v, 32'h3);
    access(1, 2'd1, 32'h1);
    idle();
    read_back(v);
    check("R10 level1 write loads", v, 32'h1);
  endtask

  task automatic t_lvl3_gate();
    logic [31:0] v;
    sec_wr_block = 1;
    access(0, 2'd3, 0);
    check("R7 read completes despite block", {29'd0, outcome}, 1);
    access(1, 2'd3, 32'h2);
    check("R7 blocked write undefined", {29'd0, outcome}, 2);
    idle();
    sec_wr_block = 0;
    read_back(v);
    check("R11 blocked write keeps bits", v, 32'h1);
    access(1, 2'd3, 32'h2);
    check("R7 unblocked write completes", {29'd0, outcome}, 1);
    idle();
    read_back(v);
    check("R10 level3 write loads", v, 32'h2);
  endtask

  task automatic t_enables();
    write_l3(32'h3);
    check("R8 both enables on", {30'd0, inv_en, ninv_en}, 3);
    write_l3(32'h1);
    check("R8 inv only", {30'd0, inv_en, ninv_en}, 2);
    write_l3(32'h2);
    check("R8 ninv only", {30'd0, inv_en, ninv_en}, 1);
    write_l3(32'h3);
    sec_l1_is64 = 1; #1;
    check("R8 64-bit secure L1 masks", {30'd0, inv_en, ninv_en}, 0);
    sec_l1_is64 = 0; #1;
  endtask

  initial begin
    defaults();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_reserved();
    t_encoding();
    t_absent();
    t_low_levels();
    t_lvl1_chain();
    t_lvl3_gate();
    t_enables();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule